// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative translation buffer for a 32-bit virtual address space split into 4 KiB pages. A lookup carries a virtual address, a 6-bit address-space tag and a store qualifier. Every stored entry is compared in parallel, and one clock later the block returns either the physical address and the entry's attribute flags or a fault. Because entries carry the address-space tag, a context switch needs no flush. An entry marked global matches under every tag.

The top three address bits select one of four segments. The user segment (`0xx`) and the kernel virtual segment (`11x`) are translated through the buffer. The two kernel physical windows (`100` cached, `101` uncached) bypass translation and never fault. Software fills entries through a write port, either at an explicit slot or at a slot chosen by a free-running counter. It can drop a single slot with the invalidate port. A flush command clears all non-global entries of one tag.

The flush is carried out by a two-state maintenance machine. `MT_IDLE` is the resting state, and it takes the transition "flush start" to `MT_SWEEP` when `fl_en` is sampled. `MT_SWEEP` visits one slot per cycle and takes the transition "sweep end" back to `MT_IDLE` after the last slot. `busy` is high in `MT_SWEEP`. While `busy` is high, write, invalidate and flush requests are dropped.

Top module: `asid_tlb`

## Requirements
- R1: After reset `rs_valid` and `busy` are 0, and every slot is invalid, so any lookup in a translated segment reports a refill fault.
- R2: A lookup sampled with `lk_req` high produces `rs_valid` high on the next cycle. On a valid hit in a translated segment (top bits `0xx` or `11x`), `rs_paddr` is the entry's 20-bit frame number followed by the 12-bit untranslated offset.
- R3: A non-global entry matches only when its tag equals `lk_asid`. An entry with the global flag matches under any tag.
- R4: In a translated segment, if no valid entry matches, `rs_refill_fault` is 1. An entry whose valid flag is clear never counts as a match. Whenever either fault is raised, `rs_paddr`, `rs_dirty` and `rs_refd` are 0.
- R5: Top bits `100` and `101` bypass translation. For these, `rs_paddr` is `{3'b000, vaddr[28:0]}` and neither fault is raised, even for a store.
- R6: `rs_uncached` is 1 for the `101` window and 0 for the `100` window. For a translated hit it equals the entry's no-cache flag.
- R7: A store that hits an entry with the read-only flag set, or with the dirty/writable flag clear, raises `rs_prot_fault` instead of translating. A load to the same entry translates normally.
- R8: With `wr_en` high and `wr_random` low, the entry is written to slot `wr_index`. The `wr_flags` layout is: bit0 valid, bit1 dirty/writable, bit2 referenced, bit3 global, bit4 read-only, bit5 no-cache.
- R9: With `wr_en` and `wr_random` both high, the entry goes to the slot given by a free-running counter, and a later lookup of it hits.
- R10: `inv_en` clears the valid flag of slot `inv_index` only; other slots keep translating.
- R11: `fl_en` starts a sweep that keeps `busy` high for exactly ENTRIES cycles. The sweep clears every non-global entry whose tag equals `fl_asid`, and leaves global entries and other tags intact. Writes issued while `busy` is high are ignored.
- R12: When several valid entries match, the lowest-numbered slot supplies the result.
- R13: On a translated hit, `rs_dirty` and `rs_refd` report the entry's dirty and referenced flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 6 | Address-space tag of the lookup |
| lk_store | input | 1 | Lookup is a store |
| rs_valid | output | 1 | Result valid (one cycle after request) |
| rs_paddr | output | 32 | Physical address |
| rs_refill_fault | output | 1 | No valid matching entry |
| rs_prot_fault | output | 1 | Store denied by entry rights |
| rs_uncached | output | 1 | Access is uncached |
| rs_dirty | output | 1 | Dirty flag of the hit entry |
| rs_refd | output | 1 | Referenced flag of the hit entry |
| wr_en | input | 1 | Write an entry |
| wr_random | input | 1 | Use counter slot instead of wr_index |
| wr_index | input | IDX_W | Explicit slot |
| wr_vpn | input | 20 | Virtual page number |
| wr_asid | input | 6 | Entry tag |
| wr_pfn | input | 20 | Physical frame number |
| wr_flags | input | 6 | Entry flags (see R8) |
| inv_en | input | 1 | Invalidate one slot |
| inv_index | input | IDX_W | Slot to invalidate |
| fl_en | input | 1 | Start flush of one tag |
| fl_asid | input | 6 | Tag to flush |
| busy | output | 1 | Flush sweep in progress |

## Verification
Lookup results are registered, so every result is due exactly one clock after the request is sampled. The bench raises `lk_req` on a falling edge, lowers it on the next falling edge, and reads the outputs right then, half a period after the capturing edge. A write, an invalidate or a flush takes effect at the edge that samples it, so a lookup issued on the following falling edge already sees the new contents. The flush check counts the falling edges on which `busy` is high and expects exactly ENTRIES of them. The lookups after the sweep are made only once `busy` has dropped.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int ASID_W   = 6;
    localparam int FLAG_W   = 6;
    localparam int SEG_W    = 3;

    // wr_flags bit positions
    localparam int FL_VALID = 0;
    localparam int FL_DIRTY = 1;
    localparam int FL_REFD  = 2;
    localparam int FL_GLOB  = 3;
    localparam int FL_RDONL = 4;
    localparam int FL_NOCAC = 5;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  pfn;
        logic              valid;
        logic              dirty;
        logic              refd;
        logic              glob;
        logic              rdonly;
        logic              nocache;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        SEG_USER,
        SEG_KPHYS_C,
        SEG_KPHYS_U,
        SEG_KVIRT
    } seg_t;

    typedef enum logic {
        MT_IDLE,
        MT_SWEEP
    } mt_state_t;
endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
    import tlb_pkg::*;
(
    input  logic [SEG_W-1:0] top_bits,
    output logic             mapped,
    output logic             uncached
);
    seg_t seg;

    always_comb begin
        unique casez (top_bits)
            3'b0??:  seg = SEG_USER;
            3'b100:  seg = SEG_KPHYS_C;
            3'b101:  seg = SEG_KPHYS_U;
            default: seg = SEG_KVIRT;
        endcase
    end

    always_comb begin
        mapped   = (seg == SEG_USER) || (seg == SEG_KVIRT);
        uncached = (seg == SEG_KPHYS_U);
    end
endmodule

// File: rtl/tlb_victim_ctr.sv
module tlb_victim_ctr #(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] victim
);
    always_ff @(posedge clk) begin
        if (!rst_n) victim <= IDX_W'(ENTRIES - 1);
        else        victim <= victim - 1'b1;
    end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              hit,
    output logic [VPN_W-1:0]  hit_pfn,
    output logic              hit_dirty,
    output logic              hit_refd,
    output logic              hit_rdonly,
    output logic              hit_nocache,
    input  logic              wr_go,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_entry_t        wr_ent,
    input  logic              inv_go,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              sw_go,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [ASID_W-1:0] sw_asid
);
    tlb_entry_t         mem [ENTRIES];
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = mem[g].valid && (mem[g].vpn == lk_vpn) &&
                          (mem[g].glob || (mem[g].asid == lk_asid));
    end

    // lowest matching slot wins
    always_comb begin
        hit         = 1'b0;
        hit_pfn     = '0;
        hit_dirty   = 1'b0;
        hit_refd    = 1'b0;
        hit_rdonly  = 1'b0;
        hit_nocache = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit         = 1'b1;
                hit_pfn     = mem[i].pfn;
                hit_dirty   = mem[i].dirty;
                hit_refd    = mem[i].refd;
                hit_rdonly  = mem[i].rdonly;
                hit_nocache = mem[i].nocache;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else begin
            if (wr_go) mem[wr_idx] <= wr_ent;
            if (inv_go) mem[inv_idx].valid <= 1'b0;
            if (sw_go && !mem[sw_idx].glob && (mem[sw_idx].asid == sw_asid))
                mem[sw_idx].valid <= 1'b0;
        end
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [31:0]       lk_vaddr,
    input  logic [5:0]        lk_asid,
    input  logic              lk_store,
    output logic              rs_valid,
    output logic [31:0]       rs_paddr,
    output logic              rs_refill_fault,
    output logic              rs_prot_fault,
    output logic              rs_uncached,
    output logic              rs_dirty,
    output logic              rs_refd,
    input  logic              wr_en,
    input  logic              wr_random,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [19:0]       wr_vpn,
    input  logic [5:0]        wr_asid,
    input  logic [19:0]       wr_pfn,
    input  logic [5:0]        wr_flags,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_index,
    input  logic              fl_en,
    input  logic [5:0]        fl_asid,
    output logic              busy
);
    mt_state_t         state, state_nx;
    logic [IDX_W-1:0]  sw_idx;
    logic [ASID_W-1:0] sw_asid;
    logic              sw_go, wr_go, inv_go;
    logic [IDX_W-1:0]  victim, wr_slot;
    tlb_entry_t        wr_ent;

    logic              seg_mapped, seg_unc;
    logic              hit, hit_dirty, hit_refd, hit_rdonly, hit_nocache;
    logic [VPN_W-1:0]  hit_pfn;

    logic [31:0]       n_paddr;
    logic              n_refill, n_prot, n_unc, n_dirty, n_refd;

    // ---------------- maintenance state machine ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            MT_IDLE:  if (fl_en) state_nx = MT_SWEEP;
            MT_SWEEP: if (sw_idx == IDX_W'(ENTRIES - 1)) state_nx = MT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= MT_IDLE;
            sw_idx  <= '0;
            sw_asid <= '0;
        end else begin
            state <= state_nx;
            if (state == MT_IDLE && fl_en) begin
                sw_idx  <= '0;
                sw_asid <= fl_asid;
            end else if (state == MT_SWEEP) begin
                sw_idx <= sw_idx + 1'b1;
            end
        end
    end

    always_comb begin
        busy   = (state == MT_SWEEP);
        sw_go  = (state == MT_SWEEP);
        wr_go  = wr_en  && (state == MT_IDLE);
        inv_go = inv_en && (state == MT_IDLE);
    end

    // ---------------- entry fill ----------------
    tlb_victim_ctr #(.ENTRIES(ENTRIES)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .victim (victim)
    );

    always_comb begin
        wr_slot        = wr_random ? victim : wr_index;
        wr_ent.vpn     = wr_vpn;
        wr_ent.asid    = wr_asid;
        wr_ent.pfn     = wr_pfn;
        wr_ent.valid   = wr_flags[FL_VALID];
        wr_ent.dirty   = wr_flags[FL_DIRTY];
        wr_ent.refd    = wr_flags[FL_REFD];
        wr_ent.glob    = wr_flags[FL_GLOB];
        wr_ent.rdonly  = wr_flags[FL_RDONL];
        wr_ent.nocache = wr_flags[FL_NOCAC];
    end

    tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_vpn      (lk_vaddr[VA_W-1:OFF_W]),
        .lk_asid     (lk_asid),
        .hit         (hit),
        .hit_pfn     (hit_pfn),
        .hit_dirty   (hit_dirty),
        .hit_refd    (hit_refd),
        .hit_rdonly  (hit_rdonly),
        .hit_nocache (hit_nocache),
        .wr_go       (wr_go),
        .wr_idx      (wr_slot),
        .wr_ent      (wr_ent),
        .inv_go      (inv_go),
        .inv_idx     (inv_index),
        .sw_go       (sw_go),
        .sw_idx      (sw_idx),
        .sw_asid     (sw_asid)
    );

    // ---------------- lookup ----------------
    tlb_seg_decode u_seg (
        .top_bits (lk_vaddr[VA_W-1:VA_W-SEG_W]),
        .mapped   (seg_mapped),
        .uncached (seg_unc)
    );

    always_comb begin
        n_paddr  = '0;
        n_refill = 1'b0;
        n_prot   = 1'b0;
        n_unc    = 1'b0;
        n_dirty  = 1'b0;
        n_refd   = 1'b0;
        if (!seg_mapped) begin
            n_paddr = {{SEG_W{1'b0}}, lk_vaddr[VA_W-SEG_W-1:0]};
            n_unc   = seg_unc;
        end else if (!hit) begin
            n_refill = 1'b1;
        end else begin
            n_prot = lk_store && (hit_rdonly || !hit_dirty);
            n_unc  = hit_nocache;
            if (!n_prot) begin
                n_paddr = {hit_pfn, lk_vaddr[OFF_W-1:0]};
                n_dirty = hit_dirty;
                n_refd  = hit_refd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !lk_req) begin
            rs_valid        <= 1'b0;
            rs_paddr        <= '0;
            rs_refill_fault <= 1'b0;
            rs_prot_fault   <= 1'b0;
            rs_uncached     <= 1'b0;
            rs_dirty        <= 1'b0;
            rs_refd         <= 1'b0;
        end else begin
            rs_valid        <= 1'b1;
            rs_paddr        <= n_paddr;
            rs_refill_fault <= n_refill;
            rs_prot_fault   <= n_prot;
            rs_uncached     <= n_unc;
            rs_dirty        <= n_dirty;
            rs_refd         <= n_refd;
        end
    end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
    parameter int ENTRIES = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_req,
    input logic [31:0] lk_vaddr,
    input logic        lk_store,
    input logic        fl_en,
    input logic        rs_valid,
    input logic [31:0] rs_paddr,
    input logic        rs_refill_fault,
    input logic        rs_prot_fault,
    input logic        rs_uncached,
    input logic        busy
);
    localparam int CNT_W = $clog2(ENTRIES) + 2;
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    // R2: result one cycle after request
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid == $past(lk_req));

    // R4: faults exclusive, address zero on fault
    a_r4_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_refill_fault || rs_prot_fault) |-> (rs_paddr == 32'h0 && !(rs_refill_fault && rs_prot_fault)));

    // R5: unmapped windows pass the address and never fault
    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && $past(lk_vaddr[31:30]) == 2'b10) |->
        (!rs_refill_fault && !rs_prot_fault && rs_paddr == {3'b000, $past(lk_vaddr[28:0])}));

    // R6: uncached attribute follows bit 29 in unmapped windows
    a_r6_uncached: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && $past(lk_vaddr[31:30]) == 2'b10) |-> (rs_uncached == $past(lk_vaddr[29])));

    // R7: protection fault only on stores
    a_r7_store_only: assert property (@(posedge clk) disable iff (!rst_n)
        rs_prot_fault |-> $past(lk_store));

    // R11: sweep starts on flush command and lasts at most ENTRIES cycles
    a_r11_sweep_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(fl_en));
    a_r11_sweep_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < CNT_W'(ENTRIES)));
endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .lk_req          (lk_req),
    .lk_vaddr        (lk_vaddr),
    .lk_store        (lk_store),
    .fl_en           (fl_en),
    .rs_valid        (rs_valid),
    .rs_paddr        (rs_paddr),
    .rs_refill_fault (rs_refill_fault),
    .rs_prot_fault   (rs_prot_fault),
    .rs_uncached     (rs_uncached),
    .busy            (busy)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 64;
    localparam int IDX_W      = $clog2(ENTRIES);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_req = 1'b0, lk_store = 1'b0;
    logic [31:0]       lk_vaddr = '0;
    logic [5:0]        lk_asid = '0;
    logic              rs_valid, rs_refill_fault, rs_prot_fault, rs_uncached, rs_dirty, rs_refd;
    logic [31:0]       rs_paddr;
    logic              wr_en = 1'b0, wr_random = 1'b0;
    logic [IDX_W-1:0]  wr_index = '0, inv_index = '0;
    logic [19:0]       wr_vpn = '0, wr_pfn = '0;
    logic [5:0]        wr_asid = '0, wr_flags = '0, fl_asid = '0;
    logic              inv_en = 1'b0, fl_en = 1'b0, busy;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asid_tlb #(.ENTRIES(ENTRIES)) u_asid_tlb (.*);

    typedef struct packed {
        logic        store;
        logic [5:0]  asid;
        logic [31:0] va;
        logic [31:0] pa;
        logic [4:0]  fl;   // refill, prot, uncached, dirty, refd
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'd5,  32'h00010ABC, 32'hAAAAAABC, 5'b00011, 8'd2},  // R2 R13
        '{1'b0, 6'd7,  32'h00010123, 32'h44444123, 5'b00110, 8'd6},  // R6 R3
        '{1'b0, 6'd6,  32'h00010123, 32'h00000000, 5'b10000, 8'd3},  // R3 wrong tag
        '{1'b0, 6'd12, 32'h00020FFF, 32'h33333FFF, 5'b00010, 8'd3},  // R3 global
        '{1'b1, 6'd5,  32'h00011004, 32'h00000000, 5'b01000, 8'd7},  // R7 read-only
        '{1'b0, 6'd5,  32'h00011004, 32'h12345004, 5'b00010, 8'd7},  // R7 load ok
        '{1'b1, 6'd5,  32'h00012008, 32'h00000000, 5'b01000, 8'd7},  // R7 not writable
        '{1'b1, 6'd5,  32'h00010010, 32'hAAAAA010, 5'b00011, 8'd8},  // R8 store ok
        '{1'b0, 6'd5,  32'h00030000, 32'h00000000, 5'b10000, 8'd4},  // R4 invalid slot
        '{1'b1, 6'd5,  32'h80001234, 32'h00001234, 5'b00000, 8'd5},  // R5 cached window
        '{1'b0, 6'd0,  32'hA0400000, 32'h00400000, 5'b00100, 8'd6},  // R6 uncached window
        '{1'b0, 6'd5,  32'hC0000777, 32'h66666777, 5'b00010, 8'd2},  // R2 kernel virtual
        '{1'b0, 6'd3,  32'h00040000, 32'h77777000, 5'b00010, 8'd12}, // R12 duplicates
        '{1'b0, 6'd5,  32'h7FFFF000, 32'h00000000, 5'b10000, 8'd4}   // R4 miss
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic st, input logic [5:0] asid, input logic [31:0] va);
        @(negedge clk);
        lk_req = 1'b1; lk_store = st; lk_asid = asid; lk_vaddr = va;
        @(negedge clk);
        lk_req = 1'b0; lk_store = 1'b0;
    endtask

    task automatic write(input logic rnd, input logic [IDX_W-1:0] idx, input logic [19:0] vpn,
                         input logic [5:0] asid, input logic [19:0] pfn, input logic [5:0] fl);
        @(negedge clk);
        wr_en = 1'b1; wr_random = rnd; wr_index = idx; wr_vpn = vpn;
        wr_asid = asid; wr_pfn = pfn; wr_flags = fl;
        @(negedge clk);
        wr_en = 1'b0; wr_random = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int busy_cycles;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 valid/busy", {30'd0, rs_valid, busy}, 32'd0);
        lookup(1'b0, 6'd0, 32'h00000000);
        check("R1 empty refill", {31'd0, rs_refill_fault}, 32'd1);

        // fill: flags bit0 valid,1 dirty,2 refd,3 global,4 rdonly,5 nocache
        write(1'b0, 6'd0, 20'h00010, 6'd5, 20'hAAAAA, 6'h07);
        write(1'b0, 6'd1, 20'h00011, 6'd5, 20'h12345, 6'h13);
        write(1'b0, 6'd2, 20'h00012, 6'd5, 20'h22222, 6'h01);
        write(1'b0, 6'd3, 20'h00020, 6'd9, 20'h33333, 6'h0B);
        write(1'b0, 6'd4, 20'h00010, 6'd7, 20'h44444, 6'h23);
        write(1'b0, 6'd5, 20'h00030, 6'd5, 20'h55555, 6'h06);
        write(1'b0, 6'd6, 20'hC0000, 6'd5, 20'h66666, 6'h03);
        write(1'b0, 6'd7, 20'h00040, 6'd3, 20'h77777, 6'h03);
        write(1'b0, 6'd8, 20'h00040, 6'd3, 20'h88888, 6'h03);

        for (int i = 0; i < NV; i++) begin
            lookup(VEC[i].store, VEC[i].asid, VEC[i].va);
            check($sformatf("R%0d vec%0d valid", VEC[i].req, i), {31'd0, rs_valid}, 32'd1);
            check($sformatf("R%0d vec%0d paddr", VEC[i].req, i), rs_paddr, VEC[i].pa);
            check($sformatf("R%0d vec%0d flags", VEC[i].req, i),
                  {27'd0, rs_refill_fault, rs_prot_fault, rs_uncached, rs_dirty, rs_refd},
                  {27'd0, VEC[i].fl});
        end

        // R8 overwrite an explicit slot
        write(1'b0, 6'd4, 20'h00010, 6'd7, 20'h4A4A4, 6'h03);
        lookup(1'b0, 6'd7, 32'h00010555);
        check("R8 overwrite", rs_paddr, 32'h4A4A4555);

        // R10 invalidate one slot
        @(negedge clk); inv_en = 1'b1; inv_index = 6'd0;
        @(negedge clk); inv_en = 1'b0;
        lookup(1'b0, 6'd5, 32'h00010000);
        check("R10 dropped slot", {31'd0, rs_refill_fault}, 32'd1);
        lookup(1'b0, 6'd7, 32'h00010000);
        check("R10 other slot kept", rs_paddr, 32'h4A4A4000);

        // R11 flush tag 5
        @(negedge clk); fl_en = 1'b1; fl_asid = 6'd5;
        @(negedge clk); fl_en = 1'b0;
        check("R11 busy raised", {31'd0, busy}, 32'd1);
        wr_en = 1'b1; wr_index = 6'd9; wr_vpn = 20'h00050; wr_asid = 6'd3;
        wr_pfn = 20'h99999; wr_flags = 6'h03;
        @(negedge clk); wr_en = 1'b0;
        busy_cycles = 2;
        for (int k = 0; k < 200 && busy; k++) begin
            @(negedge clk);
            if (busy) busy_cycles++;
        end
        check("R11 sweep length", busy_cycles, ENTRIES);
        lookup(1'b0, 6'd5, 32'h00011000);
        check("R11 tag flushed", {31'd0, rs_refill_fault}, 32'd1);
        lookup(1'b0, 6'd5, 32'hC0000000);
        check("R11 kvirt flushed", {31'd0, rs_refill_fault}, 32'd1);
        lookup(1'b0, 6'd5, 32'h00020000);
        check("R11 global kept", rs_paddr, 32'h33333000);
        lookup(1'b0, 6'd3, 32'h00040000);
        check("R11 other tag kept", rs_paddr, 32'h77777000);
        lookup(1'b0, 6'd3, 32'h00050000);
        check("R11 write while busy ignored", {31'd0, rs_refill_fault}, 32'd1);

        // R9 counter-chosen slot
        write(1'b1, 6'd0, 20'h00099, 6'd2, 20'h9ABCD, 6'h03);
        lookup(1'b0, 6'd2, 32'h00099321);
        check("R9 random slot hit", rs_paddr, 32'h9ABCD321);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule